// File: doc/BRIEF.md
# UTOPIA Receive Cell Buffer

This block is the PHY-side receive path of a UTOPIA Level 2 style cell interface. An upstream cell processor delivers one byte per cycle and flags the first byte of each cell. The block stores each cell in its own slot of a sixteen-cell buffer. Cells that end early are dropped and flagged through a sticky interrupt. A cell arriving while every slot is occupied is dropped whole and flagged as an overflow.

An ATM layer reader drains complete cells over a bus that is 8 or 16 bits wide, chosen by a parameter. Every word leaves with an odd-parity bit, and a start-of-cell pulse marks the first word of each cell. A cell-available flag tells the reader when a complete cell is waiting. Two status outputs report whether the buffer is empty or full.

Top module: `utopia_rx_cell_buf`

## Requirements
- R1: Parameter `BUS_W` sets the output bus width to 8 or 16 bits. In 16-bit mode the earlier byte of each pair is driven on bits [15:8] and the later byte on bits [7:0].
- R2: Whenever `rx_valid_o` is high, `rx_prty_o` makes the total count of ones across `rx_data_o` and `rx_prty_o` odd, in the same cycle as the data.
- R3: `rx_soc_o` is high only together with the first word of a cell, and is low for every other word.
- R4: `cfg_len_i` selects the cell length: 0 gives 52 bytes, 1 gives 53 bytes, and 2 or 3 gives 54 bytes. The setting is held constant while cells are in flight.
- R5: In 16-bit mode a 53-byte cell is sent as 27 words, and the low byte of the last word is zero. A 52-byte cell is sent as 26 words and a 54-byte cell as 27 words.
- R6: A start of cell that arrives while a cell is only partly written marks that partial cell as a runt. The runt never reaches the output and sets `runt_irq_o`. The new cell is stored in the same slot and is delivered normally.
- R7: `runt_irq_o` and `ovfl_o` stay set until a cycle with `irq_clr_i` high clears both. If a new event occurs in the same cycle as the clear, the flag stays set.
- R8: The buffer holds sixteen complete cells, and `fifo_full_o` is high exactly while sixteen are held.
- R9: `rx_clav_o` is high and `fifo_empty_o` is low while at least one complete cell is held. A cell counts as held from the cycle after its last byte is taken in, and never while it is only partly written.
- R10: A start of cell that arrives while `fifo_full_o` is high causes that whole cell to be dropped and sets `ovfl_o` on the next cycle.
- R11: An output word appears, with `rx_valid_o` high, one cycle after `rd_en_i` is sampled high while a cell is being read or available. No word appears without `rd_en_i`, and one word is sent per cycle.
- R12: Input bytes that arrive without a start-of-cell marker, while no cell is being written, are ignored. They change neither the stored data nor the status outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_len_i | input | 2 | Cell length select |
| in_valid_i | input | 1 | Input byte valid |
| in_soc_i | input | 1 | Input byte is the first byte of a cell |
| in_data_i | input | 8 | Input byte |
| rd_en_i | input | 1 | Reader requests a word |
| irq_clr_i | input | 1 | Clears the runt and overflow flags |
| rx_data_o | output | BUS_W | Output word |
| rx_prty_o | output | 1 | Odd parity of the output word |
| rx_soc_o | output | 1 | First word of a cell |
| rx_valid_o | output | 1 | Output word valid |
| rx_clav_o | output | 1 | At least one complete cell is available |
| fifo_empty_o | output | 1 | No complete cell is held |
| fifo_full_o | output | 1 | Sixteen complete cells are held |
| runt_irq_o | output | 1 | Sticky runt interrupt |
| ovfl_o | output | 1 | Sticky overflow flag |

## Verification
A cell can finish being written in the same cycle that the reader takes the last word of an older cell. In that cycle the occupancy count must stay the same, and both its increment and its decrement must take effect. The bench provokes this by streaming several cells back to back with the reader enabled. The 8-bit instance then reads a cell in about the time it takes to write one, so the two events line up repeatedly. The scoreboard judges the outcome by checking that every word arrives intact and in order, and that both instances report empty once the expected queues have drained.

// File: rtl/urx_pkg.sv
package urx_pkg;
  localparam int unsigned SLOT_BYTES = 54;

  function automatic logic [5:0] cell_bytes(input logic [1:0] sel);
    case (sel)
      2'd0:    return 6'd52;
      2'd1:    return 6'd53;
      default: return 6'd54;
    endcase
  endfunction
endpackage

// File: rtl/urx_cell_mem.sv
module urx_cell_mem #(
  parameter int unsigned DEPTH  = 864,
  parameter int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [7:0]        wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [7:0]        rd0_o,
  output logic [7:0]        rd1_o
);
  logic [7:0] mem_q [DEPTH];
  logic [ADDR_W-1:0] raddr1;

  assign raddr1 = raddr_i + ADDR_W'(1);

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rd0_o = mem_q[raddr_i];
  assign rd1_o = (raddr_i == ADDR_W'(DEPTH - 1)) ? 8'h00 : mem_q[raddr1];
endmodule

// File: rtl/urx_wr_ctrl.sv
module urx_wr_ctrl
  import urx_pkg::*;
#(
  parameter int unsigned NCELLS = 16,
  parameter int unsigned SLOT_W = $clog2(NCELLS),
  parameter int unsigned ADDR_W = $clog2(NCELLS * SLOT_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        len_sel_i,
  input  logic              valid_i,
  input  logic              soc_i,
  input  logic [7:0]        data_i,
  input  logic              room_i,
  input  logic              irq_clr_i,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [7:0]        wdata_o,
  output logic              commit_o,
  output logic              runt_irq_o,
  output logic              ovfl_o
);
  logic              active_q;
  logic [5:0]        bcnt_q;
  logic [SLOT_W-1:0] slot_q;
  logic [5:0]        len, off;
  logic              runt_set, ovfl_set;

  assign len = cell_bytes(len_sel_i);

  always_comb begin
    we_o     = 1'b0;
    commit_o = 1'b0;
    runt_set = 1'b0;
    ovfl_set = 1'b0;
    off      = bcnt_q;
    if (valid_i) begin
      if (soc_i) begin
        runt_set = active_q;        // partial cell cut short
        if (room_i) begin
          we_o = 1'b1;
          off  = 6'd0;              // roll back to slot start
        end else begin
          ovfl_set = 1'b1;
        end
      end else if (active_q) begin
        we_o     = 1'b1;
        commit_o = (bcnt_q == len - 6'd1);
      end
    end
  end

  assign addr_o  = ADDR_W'(slot_q) * ADDR_W'(SLOT_BYTES) + ADDR_W'(off);
  assign wdata_o = data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q   <= 1'b0;
      bcnt_q     <= '0;
      slot_q     <= '0;
      runt_irq_o <= 1'b0;
      ovfl_o     <= 1'b0;
    end else begin
      if (valid_i && soc_i) begin
        active_q <= room_i;
        bcnt_q   <= room_i ? 6'd1 : 6'd0;
      end else if (commit_o) begin
        active_q <= 1'b0;
        bcnt_q   <= '0;
        slot_q   <= (slot_q == SLOT_W'(NCELLS - 1)) ? '0 : slot_q + SLOT_W'(1);
      end else if (we_o) begin
        bcnt_q <= bcnt_q + 6'd1;
      end
      if (runt_set)       runt_irq_o <= 1'b1;
      else if (irq_clr_i) runt_irq_o <= 1'b0;
      if (ovfl_set)       ovfl_o <= 1'b1;
      else if (irq_clr_i) ovfl_o <= 1'b0;
    end
  end
endmodule

// File: rtl/urx_rd_ctrl.sv
module urx_rd_ctrl
  import urx_pkg::*;
#(
  parameter int unsigned BUS_W  = 8,
  parameter int unsigned NCELLS = 16,
  parameter int unsigned SLOT_W = $clog2(NCELLS),
  parameter int unsigned ADDR_W = $clog2(NCELLS * SLOT_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        len_sel_i,
  input  logic              rd_en_i,
  input  logic              avail_i,
  input  logic [7:0]        rd0_i,
  input  logic [7:0]        rd1_i,
  output logic [ADDR_W-1:0] raddr_o,
  output logic              done_o,
  output logic [BUS_W-1:0]  data_o,
  output logic              prty_o,
  output logic              soc_o,
  output logic              valid_o
);
  logic [5:0]        wpos_q, len, nwords, boff;
  logic [SLOT_W-1:0] slot_q;
  logic [BUS_W-1:0]  word;
  logic              go, last;

  assign len = cell_bytes(len_sel_i);

  if (BUS_W == 16) begin : g_w16
    assign nwords = (len + 6'd1) >> 1;
    assign boff   = {wpos_q[4:0], 1'b0};
    assign word   = {rd0_i, ((boff + 6'd1) < len) ? rd1_i : 8'h00};
  end else begin : g_w8
    assign nwords = len;
    assign boff   = wpos_q;
    assign word   = rd0_i;
  end

  assign go      = rd_en_i && ((wpos_q != 6'd0) || avail_i);
  assign last    = (wpos_q == nwords - 6'd1);
  assign done_o  = go && last;
  assign raddr_o = ADDR_W'(slot_q) * ADDR_W'(SLOT_BYTES) + ADDR_W'(boff);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wpos_q  <= '0;
      slot_q  <= '0;
      data_o  <= '0;
      prty_o  <= 1'b1;
      soc_o   <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= go;
      soc_o   <= go && (wpos_q == 6'd0);
      if (go) begin
        data_o <= word;
        prty_o <= ~^word;
        if (last) begin
          wpos_q <= '0;
          slot_q <= (slot_q == SLOT_W'(NCELLS - 1)) ? '0 : slot_q + SLOT_W'(1);
        end else begin
          wpos_q <= wpos_q + 6'd1;
        end
      end
    end
  end
endmodule

// File: rtl/utopia_rx_cell_buf.sv
module utopia_rx_cell_buf
  import urx_pkg::*;
#(
  parameter int unsigned BUS_W  = 8,
  parameter int unsigned NCELLS = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       cfg_len_i,
  input  logic             in_valid_i,
  input  logic             in_soc_i,
  input  logic [7:0]       in_data_i,
  input  logic             rd_en_i,
  input  logic             irq_clr_i,
  output logic [BUS_W-1:0] rx_data_o,
  output logic             rx_prty_o,
  output logic             rx_soc_o,
  output logic             rx_valid_o,
  output logic             rx_clav_o,
  output logic             fifo_empty_o,
  output logic             fifo_full_o,
  output logic             runt_irq_o,
  output logic             ovfl_o
);
  localparam int unsigned DEPTH  = NCELLS * SLOT_BYTES;
  localparam int unsigned ADDR_W = $clog2(DEPTH);
  localparam int unsigned SLOT_W = $clog2(NCELLS);
  localparam int unsigned CNT_W  = $clog2(NCELLS + 1);

  logic [CNT_W-1:0]  count_q;
  logic              room, commit, rd_done, we;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [7:0]        wdata, rd0, rd1;

  assign room = (count_q < CNT_W'(NCELLS));

  urx_wr_ctrl #(.NCELLS(NCELLS), .SLOT_W(SLOT_W), .ADDR_W(ADDR_W)) u_wr (
    .clk_i, .rst_ni, .len_sel_i(cfg_len_i), .valid_i(in_valid_i), .soc_i(in_soc_i),
    .data_i(in_data_i), .room_i(room), .irq_clr_i, .we_o(we), .addr_o(waddr),
    .wdata_o(wdata), .commit_o(commit), .runt_irq_o, .ovfl_o
  );

  urx_cell_mem #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_mem (
    .clk_i, .we_i(we), .waddr_i(waddr), .wdata_i(wdata), .raddr_i(raddr),
    .rd0_o(rd0), .rd1_o(rd1)
  );

  urx_rd_ctrl #(.BUS_W(BUS_W), .NCELLS(NCELLS), .SLOT_W(SLOT_W), .ADDR_W(ADDR_W)) u_rd (
    .clk_i, .rst_ni, .len_sel_i(cfg_len_i), .rd_en_i, .avail_i(rx_clav_o),
    .rd0_i(rd0), .rd1_i(rd1), .raddr_o(raddr), .done_o(rd_done),
    .data_o(rx_data_o), .prty_o(rx_prty_o), .soc_o(rx_soc_o), .valid_o(rx_valid_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) count_q <= '0;
    else         count_q <= count_q + CNT_W'(commit) - CNT_W'(rd_done);
  end

  assign rx_clav_o    = (count_q != '0);
  assign fifo_empty_o = (count_q == '0);
  assign fifo_full_o  = (count_q == CNT_W'(NCELLS));
endmodule

// File: rtl/urx_chk.sv
module urx_chk #(
  parameter int unsigned BUS_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic             in_soc_i,
  input logic             rd_en_i,
  input logic             irq_clr_i,
  input logic [BUS_W-1:0] rx_data_o,
  input logic             rx_prty_o,
  input logic             rx_soc_o,
  input logic             rx_valid_o,
  input logic             rx_clav_o,
  input logic             fifo_empty_o,
  input logic             fifo_full_o,
  input logic             runt_irq_o,
  input logic             ovfl_o
);
  AST_ODD_PARITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> (^{rx_data_o, rx_prty_o}) == 1'b1); // R2
  AST_SOC_ONLY_WITH_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_soc_o |-> rx_valid_o); // R3
  AST_CLAV_VS_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_clav_o != fifo_empty_o); // R9
  AST_START_NEEDS_CELL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && rx_soc_o) |-> $past(rx_clav_o)); // R9
  AST_FULL_NOT_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_full_o |-> !fifo_empty_o); // R8
  AST_OVERFLOW_ON_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_soc_i && fifo_full_o) |=> ovfl_o); // R10
  AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (runt_irq_o && !irq_clr_i) |=> runt_irq_o); // R7
  AST_READ_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> $past(rd_en_i)); // R11
endmodule

bind utopia_rx_cell_buf urx_chk #(.BUS_W(BUS_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_soc_i(in_soc_i),
  .rd_en_i(rd_en_i), .irq_clr_i(irq_clr_i), .rx_data_o(rx_data_o),
  .rx_prty_o(rx_prty_o), .rx_soc_o(rx_soc_o), .rx_valid_o(rx_valid_o),
  .rx_clav_o(rx_clav_o), .fifo_empty_o(fifo_empty_o), .fifo_full_o(fifo_full_o),
  .runt_irq_o(runt_irq_o), .ovfl_o(ovfl_o)
);

// File: tb/utopia_rx_cell_buf_tb.sv
`timescale 1ns/1ps
module utopia_rx_cell_buf_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cfg_len = 2'd1;
  logic       in_valid = 1'b0, in_soc = 1'b0, rd_en = 1'b0, irq_clr = 1'b0;
  logic [7:0] in_data = 8'h00;

  logic [15:0] w_data;
  logic        w_prty, w_soc, w_valid, w_clav, w_empty, w_full, w_irq, w_ovfl;
  logic [7:0]  n_data;
  logic        n_prty, n_soc, n_valid, n_clav, n_empty, n_full, n_irq, n_ovfl;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [16:0] q16[$];
  logic [8:0]  q8[$];

  always #4 clk = ~clk;

  utopia_rx_cell_buf #(.BUS_W(16)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_len_i(cfg_len), .in_valid_i(in_valid),
    .in_soc_i(in_soc), .in_data_i(in_data), .rd_en_i(rd_en), .irq_clr_i(irq_clr),
    .rx_data_o(w_data), .rx_prty_o(w_prty), .rx_soc_o(w_soc), .rx_valid_o(w_valid),
    .rx_clav_o(w_clav), .fifo_empty_o(w_empty), .fifo_full_o(w_full),
    .runt_irq_o(w_irq), .ovfl_o(w_ovfl)
  );

  utopia_rx_cell_buf #(.BUS_W(8)) u_dut_n8 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_len_i(cfg_len), .in_valid_i(in_valid),
    .in_soc_i(in_soc), .in_data_i(in_data), .rd_en_i(rd_en), .irq_clr_i(irq_clr),
    .rx_data_o(n_data), .rx_prty_o(n_prty), .rx_soc_o(n_soc), .rx_valid_o(n_valid),
    .rx_clav_o(n_clav), .fifo_empty_o(n_empty), .fifo_full_o(n_full),
    .runt_irq_o(n_irq), .ovfl_o(n_ovfl)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_of(input int seed, input int i);
    return 8'((seed * 7 + i * 13 + 5) & 255);
  endfunction

  // expected words per requirement R1/R4/R5
  task automatic push_cell(input int seed, input int len);
    for (int i = 0; i < len; i++) q8.push_back({i == 0, byte_of(seed, i)});
    for (int k = 0; k < (len + 1) / 2; k++)
      q16.push_back({k == 0, byte_of(seed, 2 * k),
                     (2 * k + 1 < len) ? byte_of(seed, 2 * k + 1) : 8'h00});
  endtask

  task automatic send_cell(input int seed, input int nbytes, input bit keep);
    for (int i = 0; i < nbytes; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_soc   = (i == 0);
      in_data  = byte_of(seed, i);
    end
    if (keep) push_cell(seed, nbytes);
    @(negedge clk);
    in_valid = 1'b0;
    in_soc   = 1'b0;
  endtask

  task automatic wait_drain(input string req);
    int t = 0;
    while ((q8.size() != 0 || q16.size() != 0 || !w_empty || !n_empty) && t < 4000) begin
      @(negedge clk);
      t++;
    end
    repeat (3) @(negedge clk);
    chk(q8.size() == 0 && q16.size() == 0, req, q8.size() + q16.size(), 0);
    chk(w_empty && n_empty && !w_clav && !n_clav, req, {w_empty, n_empty}, 3);
  endtask

  // scoreboard monitors
  always @(negedge clk) begin
    if (rst_n && w_valid) begin
      if (q16.size() == 0) chk(1'b0, "R6 unexpected word16", w_data, 0);
      else begin
        logic [16:0] e;
        e = q16.pop_front();
        chk(w_data == e[15:0], "R5 word16", w_data, e[15:0]);
        chk(w_soc == e[16], "R3 soc16", w_soc, e[16]);
        chk((^{w_data, w_prty}) == 1'b1, "R2 parity16", w_prty, ~^w_data);
      end
    end
    if (rst_n && n_valid) begin
      if (q8.size() == 0) chk(1'b0, "R6 unexpected word8", n_data, 0);
      else begin
        logic [8:0] e;
        e = q8.pop_front();
        chk(n_data == e[7:0], "R1 data8", n_data, e[7:0]);
        chk(n_soc == e[8], "R3 soc8", n_soc, e[8]);
        chk((^{n_data, n_prty}) == 1'b1, "R2 parity8", n_prty, ~^n_data);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(w_empty && n_empty && !w_full && !w_clav && !w_valid && !n_valid && !w_irq && !w_ovfl,
        "R9 reset state", {w_empty, w_full, w_clav, w_irq}, 4'b1000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R9: cell becomes visible only after its last byte; R11: held without rd_en
    cfg_len = 2'd0;
    for (int i = 0; i < 52; i++) begin
      @(negedge clk);
      if (i == 51) chk(!w_clav && !n_clav && w_empty, "R9 partial cell hidden", w_clav, 0);
      in_valid = 1'b1;
      in_soc   = (i == 0);
      in_data  = byte_of(1, i);
    end
    push_cell(1, 52);
    @(negedge clk);
    in_valid = 1'b0;
    in_soc   = 1'b0;
    chk(w_clav && n_clav && !w_empty, "R9 clav after last byte", w_clav, 1);
    repeat (5) @(negedge clk);
    chk(!w_valid && !n_valid, "R11 no output without rd_en", w_valid, 0);
    rd_en = 1'b1;
    @(negedge clk);
    chk(w_valid && w_soc && n_valid && n_soc, "R11 first word one cycle after rd_en",
        {w_valid, w_soc}, 3);
    wait_drain("R4 52-byte cells drained");

    // R12: stray bytes without start marker
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_soc   = 1'b0;
      in_data  = 8'hA5;
    end
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    chk(w_empty && n_empty && !w_irq, "R12 stray bytes ignored", w_empty, 1);
    send_cell(2, 52, 1'b1);
    wait_drain("R12 next cell intact");

    // R4/R5: 53-byte cells, padded in 16-bit mode
    cfg_len = 2'd1;
    send_cell(3, 53, 1'b1);
    send_cell(4, 53, 1'b1);
    wait_drain("R5 53-byte cells drained");

    // R6: runt then full cell
    chk(!w_irq && !n_irq, "R6 irq idle", w_irq, 0);
    send_cell(5, 20, 1'b0);
    send_cell(6, 53, 1'b1);
    chk(w_irq && n_irq, "R6 runt raises irq", w_irq, 1);
    wait_drain("R6 runt discarded");
    @(negedge clk);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    chk(!w_irq && !n_irq, "R7 irq cleared", w_irq, 0);

    // R4: 54-byte cells (select 2 and 3)
    cfg_len = 2'd2;
    send_cell(7, 54, 1'b1);
    wait_drain("R4 54-byte cell");
    cfg_len = 2'd3;
    send_cell(8, 54, 1'b1);
    wait_drain("R4 select 3 gives 54");

    // R8/R10: fill sixteen, drop the seventeenth
    cfg_len = 2'd0;
    rd_en = 1'b0;
    for (int c = 0; c < 16; c++) begin
      chk(!w_full, "R8 not full early", w_full, 0);
      send_cell(20 + c, 52, 1'b1);
    end
    chk(w_full && n_full && w_clav, "R8 full at sixteen", w_full, 1);
    chk(!w_ovfl, "R10 no overflow yet", w_ovfl, 0);
    send_cell(99, 52, 1'b0);
    chk(w_ovfl && n_ovfl && w_full, "R10 overflow flagged", w_ovfl, 1);
    chk(!w_irq && !n_irq, "R6 drop is not a runt", w_irq, 0);
    rd_en = 1'b1;
    wait_drain("R10 dropped cell absent");
    @(negedge clk);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    chk(!w_ovfl && !n_ovfl, "R7 overflow cleared", w_ovfl, 0);

    // commit and read completion in the same cycle
    for (int c = 0; c < 8; c++) send_cell(40 + c, 52, 1'b1);
    wait_drain("R9 streaming count consistent");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule